// File: doc/BRIEF.md
# Return-instruction execution unit

This unit sits beside the execute stage of an 8-bit accumulator-style core. It handles two single-word return instructions. The first is an interrupt return. It pops the return-address stack into the program counter and re-arms a global interrupt enable. It can also reload the working, status and bank-select registers from shadow copies. The second is a literal return. It pops the return address and puts an 8-bit immediate into the working register. The unit does not touch the status register or the upper program-counter latches.

The unit holds the hardware return-address stack. An external call path pushes onto it, and both return instructions pop from it. The unit also holds the shadow register set, which is filled when the interrupt-entry logic pulses a capture strobe. It keeps one bit recording the priority of the interrupt being serviced. Each return takes two clock cycles. In the first cycle the results are registered. In the second cycle `busy` is high, so the fetch stage drops its prefetched word. The four internal phases of an instruction cycle are folded into one clock: decode and the stack read are combinational, and all writes land on that clock edge.

Top module: `ret_exec_unit`

## Requirements
- R1: After reset, `pc_load`, `busy`, `w_we`, `status_we`, `bsr_we`, `gie_high_set`, `gie_low_set` and `stk_underflow` are all 0, and the return stack is empty.
- R2: An accepted interrupt return (`instr_word[15:1]` = 15'h0008, so the word is 16'h0010 or 16'h0011) pops the stack. In the next cycle `pc_load` is 1 for one cycle, and `pc_value` holds the address that was on top of the stack.
- R3: For an interrupt return with `instr_word[0]`=1, the cycle that carries `pc_load` also has `w_we`, `status_we` and `bsr_we` set, with the shadow values on the write-data outputs. With `instr_word[0]`=0, none of the three write strobes is set.
- R4: An interrupt return raises exactly one enable pulse. If `prio_en`=0, it is `gie_high_set`. If `prio_en`=1, it is `gie_high_set` when the recorded priority is high and `gie_low_set` when it is low.
- R5: An accepted literal return (`instr_word[15:8]` = 8'h0C) pops the stack into `pc_value` with `pc_load`. It sets `w_we` with `w_wdata` = `instr_word[7:0]`. It raises no status or bank-select write and no enable pulse.
- R6: `busy` is 1 for exactly the one cycle after a return is accepted. Any `instr_valid` during that cycle is ignored.
- R7: A pulse on `int_enter` copies `w_in`, `status_in` and `bsr_in` into the shadow set and records `int_high` as the priority. The shadow set and the priority bit change at no other time.
- R8: A pop from an empty stack loads `pc_value` = 0 and sets `stk_underflow`. The flag stays set until reset.
- R9: The stack is last-in first-out and holds up to DEPTH entries of AW bits. A push while it is full is dropped.
- R10: `instr_valid` with any other opcode produces no output pulse and leaves the stack unchanged.
- R11: When `push_en` and an accepted return fall in the same cycle, the pop is performed and the push is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 16 | Instruction to decode |
| push_en | input | 1 | Push a return address (call path) |
| push_addr | input | AW | Address to push |
| int_enter | input | 1 | Interrupt-entry capture strobe |
| int_high | input | 1 | Entering interrupt is high priority |
| prio_en | input | 1 | Priority levels enabled |
| w_in | input | DW | Current working register |
| status_in | input | SW | Current status register |
| bsr_in | input | BW | Current bank-select register |
| pc_load | output | 1 | Load program counter |
| pc_value | output | AW | New program counter value |
| w_we | output | 1 | Working register write |
| w_wdata | output | DW | Working register data |
| status_we | output | 1 | Status register write |
| status_wdata | output | SW | Status register data |
| bsr_we | output | 1 | Bank-select register write |
| bsr_wdata | output | BW | Bank-select register data |
| gie_high_set | output | 1 | Set high-priority (or single) global enable |
| gie_low_set | output | 1 | Set low-priority global enable |
| busy | output | 1 | Flush cycle in progress |
| stk_underflow | output | 1 | Sticky empty-pop flag |

## Verification
The bench builds the unit with DEPTH=4 and the default widths (AW=21, DW=8, SW=5, BW=4). A four-entry stack can be filled to the point where a push is dropped, and emptied to an underflow, within a few operations. Random traffic therefore reaches the full and empty boundaries many times rather than only once. The 21-bit address width is kept, so full-width return addresses are popped and compared.

// File: rtl/ret_pkg.sv
package ret_pkg;
  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_IRET = 2'd1,
    RK_LRET = 2'd2
  } ret_kind_e;

  localparam logic [14:0] IRET_PREFIX = 15'h0008;
  localparam logic [7:0]  LRET_PREFIX = 8'h0C;
endpackage

// File: rtl/ret_decode.sv
module ret_decode
  import ret_pkg::*;
(
  input  logic [15:0] word,
  output ret_kind_e   kind,
  output logic        fast,
  output logic [7:0]  lit
);
  always_comb begin
    kind = RK_NONE;
    if (word[15:1] == IRET_PREFIX)      kind = RK_IRET;
    else if (word[15:8] == LRET_PREFIX) kind = RK_LRET;
    fast = word[0];
    lit  = word[7:0];
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 31,
  parameter int AW    = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] top_data,
  output logic          underflow
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam logic [SPW-1:0] DEPTH_V = SPW'(DEPTH);

  logic [AW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp_q, sp_d;
  logic           uf_q, uf_d;
  logic           wr_en;

  always_comb begin
    sp_d  = sp_q;
    uf_d  = uf_q;
    wr_en = 1'b0;
    if (pop) begin
      if (sp_q == '0) uf_d = 1'b1;
      else            sp_d = sp_q - 1'b1;
    end else if (push && (sp_q < DEPTH_V)) begin
      wr_en = 1'b1;
      sp_d  = sp_q + 1'b1;
    end
    top_data = (sp_q == '0) ? '0 : mem[sp_q - 1'b1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      uf_q <= 1'b0;
    end else begin
      sp_q <= sp_d;
      uf_q <= uf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[sp_q] <= push_data;
  end

  assign underflow = uf_q;

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= DEPTH_V);
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    uf_q |=> uf_q);
endmodule

// File: rtl/ctx_shadow.sv
module ctx_shadow #(
  parameter int DW = 8,
  parameter int SW = 5,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          prio_in,
  input  logic [DW-1:0] w_in,
  input  logic [SW-1:0] st_in,
  input  logic [BW-1:0] bsr_in,
  output logic [DW-1:0] w_sh,
  output logic [SW-1:0] st_sh,
  output logic [BW-1:0] bsr_sh,
  output logic          prio_high
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_sh      <= '0;
      st_sh     <= '0;
      bsr_sh    <= '0;
      prio_high <= 1'b0;
    end else if (capture) begin
      w_sh      <= w_in;
      st_sh     <= st_in;
      bsr_sh    <= bsr_in;
      prio_high <= prio_in;
    end
  end

  a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(w_sh) && $stable(st_sh) && $stable(bsr_sh) && $stable(prio_high)));
endmodule

// File: rtl/ret_exec_unit.sv
module ret_exec_unit
  import ret_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  parameter int DW    = 8,
  parameter int SW    = 5,
  parameter int BW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [15:0]   instr_word,
  input  logic          push_en,
  input  logic [AW-1:0] push_addr,
  input  logic          int_enter,
  input  logic          int_high,
  input  logic          prio_en,
  input  logic [DW-1:0] w_in,
  input  logic [SW-1:0] status_in,
  input  logic [BW-1:0] bsr_in,
  output logic          pc_load,
  output logic [AW-1:0] pc_value,
  output logic          w_we,
  output logic [DW-1:0] w_wdata,
  output logic          status_we,
  output logic [SW-1:0] status_wdata,
  output logic          bsr_we,
  output logic [BW-1:0] bsr_wdata,
  output logic          gie_high_set,
  output logic          gie_low_set,
  output logic          busy,
  output logic          stk_underflow
);
  localparam int LW = (DW < 8) ? DW : 8;

  // reset: asserted asynchronously, released on a clock edge
  logic rs_a_q, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a_q <= 1'b0;
      rs_n   <= 1'b0;
    end else begin
      rs_a_q <= 1'b1;
      rs_n   <= rs_a_q;
    end
  end

  ret_kind_e     kind;
  logic          fast;
  logic [7:0]    lit;
  logic [AW-1:0] stk_top;
  logic [DW-1:0] w_sh;
  logic [SW-1:0] st_sh;
  logic [BW-1:0] bsr_sh;
  logic          prio_high;
  logic          accept;

  ret_decode u_dec (.word(instr_word), .kind(kind), .fast(fast), .lit(lit));

  assign accept = instr_valid && !busy && (kind != RK_NONE);

  ret_stack #(.DEPTH(DEPTH), .AW(AW)) u_stk (
    .clk(clk), .rst_n(rs_n), .push(push_en), .push_data(push_addr),
    .pop(accept), .top_data(stk_top), .underflow(stk_underflow));

  ctx_shadow #(.DW(DW), .SW(SW), .BW(BW)) u_sh (
    .clk(clk), .rst_n(rs_n), .capture(int_enter), .prio_in(int_high),
    .w_in(w_in), .st_in(status_in), .bsr_in(bsr_in),
    .w_sh(w_sh), .st_sh(st_sh), .bsr_sh(bsr_sh), .prio_high(prio_high));

  logic          pcl_d, wwe_d, swe_d, bwe_d, gh_d, gl_d, busy_d;
  logic [AW-1:0] pcv_d;
  logic [DW-1:0] wd_d;
  logic [SW-1:0] sd_d;
  logic [BW-1:0] bd_d;

  always_comb begin
    pcl_d  = accept;
    busy_d = accept;
    pcv_d  = accept ? stk_top : '0;
    wwe_d  = 1'b0;  wd_d = '0;
    swe_d  = 1'b0;  sd_d = '0;
    bwe_d  = 1'b0;  bd_d = '0;
    gh_d   = 1'b0;  gl_d = 1'b0;
    if (accept && kind == RK_LRET) begin
      wwe_d = 1'b1;
      wd_d  = DW'(lit[LW-1:0]);
    end
    if (accept && kind == RK_IRET) begin
      if (!prio_en || prio_high) gh_d = 1'b1;
      else                       gl_d = 1'b1;
      if (fast) begin
        wwe_d = 1'b1;  wd_d = w_sh;
        swe_d = 1'b1;  sd_d = st_sh;
        bwe_d = 1'b1;  bd_d = bsr_sh;
      end
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      pc_load <= 1'b0;  pc_value <= '0;
      w_we <= 1'b0;  w_wdata <= '0;
      status_we <= 1'b0;  status_wdata <= '0;
      bsr_we <= 1'b0;  bsr_wdata <= '0;
      gie_high_set <= 1'b0;  gie_low_set <= 1'b0;
      busy <= 1'b0;
    end else begin
      pc_load <= pcl_d;  pc_value <= pcv_d;
      w_we <= wwe_d;  w_wdata <= wd_d;
      status_we <= swe_d;  status_wdata <= sd_d;
      bsr_we <= bwe_d;  bsr_wdata <= bd_d;
      gie_high_set <= gh_d;  gie_low_set <= gl_d;
      busy <= busy_d;
    end
  end

  a_r6_single_flush: assert property (@(posedge clk) disable iff (!rs_n)
    busy |=> !busy);
  a_r2_load_in_flush: assert property (@(posedge clk) disable iff (!rs_n)
    pc_load |-> busy);
  a_r4_one_enable: assert property (@(posedge clk) disable iff (!rs_n)
    $onehot0({gie_high_set, gie_low_set}));
  a_r3_restore_group: assert property (@(posedge clk) disable iff (!rs_n)
    status_we |-> (w_we && bsr_we && gie_high_set != gie_low_set));
  a_r5_write_needs_load: assert property (@(posedge clk) disable iff (!rs_n)
    w_we |-> pc_load);
endmodule

// File: tb/ret_exec_unit_tb.sv
module ret_exec_unit_tb_top;
  localparam int DEPTH = 4;
  localparam int AW = 21, DW = 8, SW = 5, BW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [15:0] instr_word = '0;
  logic push_en = 1'b0;
  logic [AW-1:0] push_addr = '0;
  logic int_enter = 1'b0, int_high = 1'b0, prio_en = 1'b0;
  logic [DW-1:0] w_in = '0;
  logic [SW-1:0] status_in = '0;
  logic [BW-1:0] bsr_in = '0;
  logic pc_load, w_we, status_we, bsr_we, gie_high_set, gie_low_set, busy, stk_underflow;
  logic [AW-1:0] pc_value;
  logic [DW-1:0] w_wdata;
  logic [SW-1:0] status_wdata;
  logic [BW-1:0] bsr_wdata;

  always #10 clk = ~clk;

  ret_exec_unit #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .SW(SW), .BW(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .push_en(push_en), .push_addr(push_addr), .int_enter(int_enter),
    .int_high(int_high), .prio_en(prio_en), .w_in(w_in), .status_in(status_in),
    .bsr_in(bsr_in), .pc_load(pc_load), .pc_value(pc_value), .w_we(w_we),
    .w_wdata(w_wdata), .status_we(status_we), .status_wdata(status_wdata),
    .bsr_we(bsr_we), .bsr_wdata(bsr_wdata), .gie_high_set(gie_high_set),
    .gie_low_set(gie_low_set), .busy(busy), .stk_underflow(stk_underflow));

  int checks = 0, failures = 0;
  logic done = 1'b0;

  // reference model
  logic [AW-1:0] m_stk [DEPTH];
  int m_cnt = 0;
  logic m_uf = 1'b0;
  logic [DW-1:0] m_w;
  logic [SW-1:0] m_s;
  logic [BW-1:0] m_b;
  logic m_hi = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_iret(input logic [15:0] wd);
    return wd[15:1] == 15'h0008;
  endfunction
  function automatic bit is_lret(input logic [15:0] wd);
    return wd[15:8] == 8'h0C;
  endfunction

  function automatic logic [AW-1:0] model_pop();
    logic [AW-1:0] v;
    if (m_cnt == 0) begin m_uf = 1'b1; v = '0; end
    else begin m_cnt--; v = m_stk[m_cnt]; end
    return v;
  endfunction

  task automatic do_push(input logic [AW-1:0] a);
    @(negedge clk);
    push_en = 1'b1; push_addr = a;
    @(negedge clk);
    push_en = 1'b0;
    if (m_cnt < DEPTH) begin m_stk[m_cnt] = a; m_cnt++; end
  endtask

  task automatic do_enter(input logic hi);
    @(negedge clk);
    int_enter = 1'b1; int_high = hi;
    w_in = DW'($urandom); status_in = SW'($urandom); bsr_in = BW'($urandom);
    m_w = w_in; m_s = status_in; m_b = bsr_in; m_hi = hi;
    @(negedge clk);
    int_enter = 1'b0;
    // R7: inputs changing without the strobe must not reach the shadow
    w_in = DW'($urandom); status_in = SW'($urandom); bsr_in = BW'($urandom);
    int_high = ~hi;
  endtask

  // issue one instruction; optional push in same cycle; optional word during flush
  task automatic do_instr(input logic [15:0] wd, input bit with_push, input bit poke_flush);
    bit ir, lr, acc;
    logic [AW-1:0] exp_pc;
    ir = is_iret(wd); lr = is_lret(wd); acc = ir || lr;
    @(negedge clk);
    instr_valid = 1'b1; instr_word = wd;
    if (with_push) begin push_en = 1'b1; push_addr = AW'($urandom); end
    exp_pc = '0;
    if (acc) exp_pc = model_pop();
    else if (with_push && m_cnt < DEPTH) begin m_stk[m_cnt] = push_addr; m_cnt++; end
    @(negedge clk);
    instr_valid = 1'b0; push_en = 1'b0;
    if (!acc) begin
      chk(!pc_load && !busy && !w_we && !gie_high_set && !gie_low_set, "R10 other opcode",
          {pc_load, busy, w_we, gie_high_set}, 0);
      return;
    end
    chk(pc_load === 1'b1 && pc_value === exp_pc, "R2/R5 pc pop", pc_value, exp_pc);
    chk(busy === 1'b1, "R6 busy in flush", busy, 1);
    chk(stk_underflow === m_uf, "R8 underflow flag", stk_underflow, m_uf);
    if (lr) begin
      chk(w_we && w_wdata == wd[7:0], "R5 literal to W", {w_we, w_wdata}, {1'b1, wd[7:0]});
      chk(!status_we && !bsr_we && !gie_high_set && !gie_low_set, "R5 no side effects",
          {status_we, bsr_we, gie_high_set, gie_low_set}, 0);
    end else begin
      bit eh;
      eh = !prio_en || m_hi;
      chk(gie_high_set == eh && gie_low_set == !eh, "R4 enable choice",
          {gie_high_set, gie_low_set}, {eh, !eh});
      if (wd[0])
        chk(w_we && status_we && bsr_we && w_wdata == m_w && status_wdata == m_s && bsr_wdata == m_b,
            "R3 fast restore", {w_wdata, 3'b0, status_wdata, 4'b0, bsr_wdata}, {m_w, 3'b0, m_s, 4'b0, m_b});
      else
        chk(!w_we && !status_we && !bsr_we, "R3 no restore", {w_we, status_we, bsr_we}, 0);
    end
    if (poke_flush) begin
      instr_valid = 1'b1; instr_word = 16'h0C55;
    end
    @(negedge clk);
    instr_valid = 1'b0;
    chk(!busy && !pc_load && !w_we, "R6 flush ignores input", {busy, pc_load, w_we}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!pc_load && !busy && !w_we && !status_we && !bsr_we && !gie_high_set && !gie_low_set
        && !stk_underflow, "R1 reset state",
        {pc_load, busy, w_we, status_we, bsr_we, gie_high_set, gie_low_set, stk_underflow}, 0);

    // R9: fill past depth, drain LIFO
    for (int i = 0; i < DEPTH + 1; i++) do_push(AW'(21'h1F0000 + i));
    for (int i = 0; i < DEPTH; i++) do_instr(16'h0C00 | 16'(i), 1'b0, 1'b0);
    // R8: empty pop gives zero and sets sticky flag
    do_instr(16'h0CA5, 1'b0, 1'b0);
    do_push(21'h12345);
    do_instr(16'h0010, 1'b0, 1'b0);
    chk(stk_underflow === 1'b1, "R8 flag stays set", stk_underflow, 1);

    // R7/R3/R4 directed
    prio_en = 1'b1;
    do_enter(1'b0);
    do_push(21'h00ABC);
    do_instr(16'h0011, 1'b0, 1'b1);
    do_enter(1'b1);
    do_push(21'h1FFFF);
    do_instr(16'h0011, 1'b0, 1'b0);
    prio_en = 1'b0;
    do_enter(1'b0);
    do_push(21'h00001);
    do_instr(16'h0010, 1'b0, 1'b0);

    // R11: push with accepted return is dropped
    do_push(21'h0AAAA);
    do_instr(16'h0C7E, 1'b1, 1'b0);
    do_instr(16'h0C7F, 1'b0, 1'b0);

    // R10: other opcodes leave stack alone
    do_push(21'h05555);
    do_instr(16'h0012, 1'b0, 1'b0);
    do_instr(16'h0D00, 1'b0, 1'b0);
    do_instr(16'h0C11, 1'b0, 1'b0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom % 8);
      prio_en = 1'($urandom);
      case (op)
        0, 1: do_push(AW'($urandom));
        2: do_enter(1'($urandom));
        3: do_instr(16'h0010 | 16'($urandom % 2), 1'($urandom), 1'($urandom));
        4, 5: do_instr(16'h0C00 | 16'($urandom % 256), 1'($urandom), 1'($urandom));
        default: do_instr(16'($urandom), 1'b0, 1'b0);
      endcase
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule